// File: doc/BRIEF.md
# Flash Operation Status Flag Generator

This block sits in the read-data path of a NOR-style flash memory. While an internal program or erase sequence is running, a read does not return stored cell contents. It returns a status word instead. The word carries a polarity-inverted data bit that signals completion, bits that flip on every access, a time-limit flag, and a flag that shows whether the erase has started. Between operations, and for reads that target a sector not involved in a suspended erase, the array data passes through unchanged.

An internal sequencer supplies the current operating mode, the top bit of the byte being programmed, a sector-match indication and a time-limit flag. The host side supplies a read strobe and an output enable. The two access-toggled bits advance only on the rising edge of a read strobe that is qualified by output enable. Both are cleared when a new operation begins from idle.

Top module: `flash_stat_gen`

## Requirements
- R1: Mode codes are 0 idle, 1 programming, 2 erasing, 3 sector-erase wait window, 4 erase-suspend read, 5 erase-suspend program. Codes 6 and 7 behave as idle. In idle, `read_data` equals `array_data`, and this includes the state after reset.
- R2: In modes 1 and 5, `read_data` bit 7 is the inverse of `prog_msb`, bit 3 is 0 and bit 2 is 1.
- R3: In mode 2, bit 7 is 0 and bit 3 is 1. In mode 3, bit 7 is 0 and bit 3 is 0. A finished erase shows the erased array byte (bit 7 = 1) through the idle pass-through.
- R4: In modes 1, 2, 3 and 5, bit 6 presents a toggle state. That state inverts once for each qualified read rising edge and holds otherwise.
- R5: In modes 1, 2, 3 and 5, bit 5 equals `time_limit`. In mode 4 with a sector match, bit 5 is 0.
- R6: In mode 4 with `sector_hit` = 1, bit 7 and bit 6 are 1 and bit 2 presents a second toggle state. That state inverts once per qualified read rising edge in mode 4 with a sector match, and also in modes 2 and 3. It holds otherwise.
- R7: In mode 4 with `sector_hit` = 0, `read_data` equals `array_data`, and reads in that condition advance neither toggle state.
- R8: Both toggle states clear to 0 at the clock edge where the mode leaves idle for a busy mode. Moving between busy modes (for example from 2 to 4 and back) keeps them.
- R9: Whenever a status word is shown, bits 4, 1 and 0 are 0.
- R10: A qualified read edge is a rise of (`rd_strobe` AND `out_en`). A strobe held high counts once, and strobes with `out_en` = 0 count zero times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_mode | input | 3 | Operating mode code from the sequencer |
| array_data | input | DATA_W | Data read from the cell array |
| prog_msb | input | 1 | Bit 7 of the byte being programmed |
| sector_hit | input | 1 | Read address lies inside the erase-suspended sector |
| time_limit | input | 1 | Current operation has exceeded its time limit |
| rd_strobe | input | 1 | Read access strobe |
| out_en | input | 1 | Output enable qualifying the read strobe |
| read_data | output | DATA_W | Status word or pass-through array data |

## Verification
The bench targets a read strobe held high over several cycles. A design that counted levels instead of edges would flip the toggle bits on every cycle. It also drives strobes with output enable off, where an unqualified design would advance the toggles. It steps from erase into erase-suspend and back: a design that cleared on any mode change would restart the toggle phase there, while one that never cleared would carry an old phase into a new operation started from idle. Reads of a non-suspended sector must pass data and leave both toggles untouched, and the invalid mode codes must behave as idle.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE     = 3'd0,
    MODE_PROG     = 3'd1,
    MODE_ERASE    = 3'd2,
    MODE_SEWAIT   = 3'd3,
    MODE_SUSP_RD  = 3'd4,
    MODE_SUSP_PGM = 3'd5
  } op_mode_e;

  // status bit positions decoded by the host polling routine
  localparam int unsigned POS_POLL  = 7;
  localparam int unsigned POS_TGL   = 6;
  localparam int unsigned POS_TMO   = 5;
  localparam int unsigned POS_TMR   = 3;
  localparam int unsigned POS_STGL  = 2;

  // toggle register slots
  localparam int unsigned TG_MAIN = 0;
  localparam int unsigned TG_SUSP = 1;
  localparam int unsigned TG_NUM  = 2;

  function automatic op_mode_e norm_mode(input logic [2:0] raw);
    if (raw > 3'd5) return MODE_IDLE;
    return op_mode_e'(raw);
  endfunction

endpackage

// File: rtl/flash_stat_evt.sv
module flash_stat_evt
  import flash_stat_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  op_mode_e mode,
  input  logic     rd_strobe,
  input  logic     out_en,
  output logic     rd_rise,
  output logic     op_start
);

  logic     rd_qual;
  logic     rd_q, rd_q_nxt;
  op_mode_e mode_q, mode_q_nxt;

  always_comb begin
    rd_qual    = rd_strobe & out_en;
    rd_q_nxt   = rd_qual;
    mode_q_nxt = mode;
    rd_rise    = rd_qual & ~rd_q;
    op_start   = (mode_q == MODE_IDLE) && (mode != MODE_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      mode_q <= MODE_IDLE;
    end else begin
      rd_q   <= rd_q_nxt;
      mode_q <= mode_q_nxt;
    end
  end

  // R10: two rises never come back to back
  a_r10_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise |=> !rd_rise);

  // R8: a start is a one-cycle event unless the mode drops to idle again
  a_r8_start_once: assert property (@(posedge clk) disable iff (!rst_n)
    op_start && (mode != MODE_IDLE) |=> !op_start || ($past(mode) == MODE_IDLE));

endmodule

// File: rtl/flash_stat_tgl.sv
module flash_stat_tgl #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] adv,
  output logic [N-1:0] tgl
);

  logic [N-1:0] tgl_nxt;
  logic [N-1:0] tgl_en;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      tgl_en[i]  = clr | adv[i];
      tgl_nxt[i] = clr ? 1'b0 : ~tgl[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tgl[i] <= 1'b0;
      else if (tgl_en[i]) tgl[i] <= tgl_nxt[i];
    end

    // R4 / R6: one qualified edge inverts the bit exactly once
    a_r4_flip: assert property (@(posedge clk) disable iff (!rst_n)
      adv[i] && !clr |=> tgl[i] != $past(tgl[i]));

    // R10: no edge, no change
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !adv[i] && !clr |=> $stable(tgl[i]));
  end

  // R8: starting an operation clears every toggle
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (tgl == '0));

endmodule

// File: rtl/flash_stat_mux.sv
module flash_stat_mux
  import flash_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  op_mode_e          mode,
  input  logic              sec_hit,
  input  logic              tmo,
  input  logic              prog_msb,
  input  logic [DATA_W-1:0] arr_data,
  input  logic              tg_main,
  input  logic              tg_susp,
  output logic [DATA_W-1:0] status
);

  logic [DATA_W-1:0] word;
  logic              stat_on;

  always_comb begin
    word    = '0;
    stat_on = 1'b1;
    unique case (mode)
      MODE_PROG, MODE_SUSP_PGM: begin
        word[POS_POLL] = ~prog_msb;
        word[POS_TGL]  = tg_main;
        word[POS_TMO]  = tmo;
        word[POS_STGL] = 1'b1;
      end
      MODE_ERASE: begin
        word[POS_TGL]  = tg_main;
        word[POS_TMO]  = tmo;
        word[POS_TMR]  = 1'b1;
        word[POS_STGL] = tg_susp;
      end
      MODE_SEWAIT: begin
        word[POS_TGL]  = tg_main;
        word[POS_TMO]  = tmo;
        word[POS_STGL] = tg_susp;
      end
      MODE_SUSP_RD: begin
        if (sec_hit) begin
          word[POS_POLL] = 1'b1;
          word[POS_TGL]  = 1'b1;
          word[POS_STGL] = tg_susp;
        end else begin
          stat_on = 1'b0;
        end
      end
      default: stat_on = 1'b0;
    endcase
    status = stat_on ? word : arr_data;
  end

endmodule

// File: rtl/flash_stat_gen.sv
module flash_stat_gen
  import flash_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_mode,
  input  logic [DATA_W-1:0] array_data,
  input  logic              prog_msb,
  input  logic              sector_hit,
  input  logic              time_limit,
  input  logic              rd_strobe,
  input  logic              out_en,
  output logic [DATA_W-1:0] read_data
);

  localparam int unsigned SYNC_LEN = 2;

  logic [SYNC_LEN-1:0] rst_pipe;
  logic                rst_core_n;
  op_mode_e            mode;
  logic                rd_rise, op_start;
  logic [TG_NUM-1:0]   adv, tgl;
  logic                main_mode, susp_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe[SYNC_LEN-1];

  always_comb begin
    mode      = norm_mode(op_mode);
    main_mode = (mode == MODE_PROG) || (mode == MODE_ERASE) ||
                (mode == MODE_SEWAIT) || (mode == MODE_SUSP_PGM);
    susp_mode = (mode == MODE_ERASE) || (mode == MODE_SEWAIT) ||
                ((mode == MODE_SUSP_RD) && sector_hit);
    adv          = '0;
    adv[TG_MAIN] = rd_rise & main_mode;
    adv[TG_SUSP] = rd_rise & susp_mode;
  end

  flash_stat_evt u_evt (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .mode     (mode),
    .rd_strobe(rd_strobe),
    .out_en   (out_en),
    .rd_rise  (rd_rise),
    .op_start (op_start)
  );

  flash_stat_tgl #(.N(TG_NUM)) u_tgl (
    .clk  (clk),
    .rst_n(rst_core_n),
    .clr  (op_start),
    .adv  (adv),
    .tgl  (tgl)
  );

  flash_stat_mux #(.DATA_W(DATA_W)) u_mux (
    .mode    (mode),
    .sec_hit (sector_hit),
    .tmo     (time_limit),
    .prog_msb(prog_msb),
    .arr_data(array_data),
    .tg_main (tgl[TG_MAIN]),
    .tg_susp (tgl[TG_SUSP]),
    .status  (read_data)
  );

  a_r2_prog_poll: assert property (@(posedge clk) disable iff (!rst_core_n)
    (op_mode == 3'd1 || op_mode == 3'd5) |-> read_data[7] == ~prog_msb);

  a_r3_erase_poll: assert property (@(posedge clk) disable iff (!rst_core_n)
    (op_mode == 3'd2 || op_mode == 3'd3) |-> read_data[7] == 1'b0);

  a_r9_zero_bits: assert property (@(posedge clk) disable iff (!rst_core_n)
    (op_mode inside {3'd1, 3'd2, 3'd3, 3'd5}) |-> read_data[4] == 1'b0 && read_data[1:0] == 2'b00);

  a_r5_timeout: assert property (@(posedge clk) disable iff (!rst_core_n)
    (op_mode inside {3'd1, 3'd2, 3'd3, 3'd5}) |-> read_data[5] == time_limit);

endmodule

// File: tb/tb_flash_stat_gen.sv
module tb_flash_stat_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op_mode = 3'd0;
  logic [7:0] array_data = 8'h00;
  logic       prog_msb = 1'b0;
  logic       sector_hit = 1'b0;
  logic       time_limit = 1'b0;
  logic       rd_strobe = 1'b0;
  logic       out_en = 1'b0;
  logic [7:0] read_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic       m_t6, m_t2, m_rdq;
  logic [2:0] m_prev;

  always #2 clk = ~clk;

  flash_stat_gen #(.DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .array_data(array_data),
    .prog_msb(prog_msb), .sector_hit(sector_hit), .time_limit(time_limit),
    .rd_strobe(rd_strobe), .out_en(out_en), .read_data(read_data)
  );

  function automatic logic [2:0] nmode(input logic [2:0] m);
    return (m > 3'd5) ? 3'd0 : m;
  endfunction

  // reference model of the two toggle bits, from R4, R6, R7, R8, R10
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_t6 <= 1'b0; m_t2 <= 1'b0; m_rdq <= 1'b0; m_prev <= 3'd0;
    end else begin
      logic [2:0] nm;
      logic rise;
      nm   = nmode(op_mode);
      rise = rd_strobe && out_en && !m_rdq;
      if (m_prev == 3'd0 && nm != 3'd0) begin
        m_t6 <= 1'b0; m_t2 <= 1'b0;
      end else if (rise) begin
        if (nm inside {3'd1, 3'd2, 3'd3, 3'd5}) m_t6 <= ~m_t6;
        if (nm inside {3'd2, 3'd3} || (nm == 3'd4 && sector_hit)) m_t2 <= ~m_t2;
      end
      m_rdq  <= rd_strobe && out_en;
      m_prev <= nm;
    end
  end

  function automatic logic [7:0] exp_word(input logic [2:0] m, input logic [7:0] arr,
      input logic msb, input logic hit, input logic tmo, input logic t6, input logic t2);
    logic [7:0] w;
    w = 8'h00;
    case (nmode(m))
      3'd1, 3'd5: begin w[7] = ~msb; w[6] = t6; w[5] = tmo; w[2] = 1'b1; end
      3'd2:       begin w[6] = t6; w[5] = tmo; w[3] = 1'b1; w[2] = t2; end
      3'd3:       begin w[6] = t6; w[5] = tmo; w[2] = t2; end
      3'd4:       if (hit) begin w[7] = 1'b1; w[6] = 1'b1; w[2] = t2; end else w = arr;
      default:    w = arr;
    endcase
    return w;
  endfunction

  function automatic string req_of(input logic [2:0] m, input logic hit);
    case (nmode(m))
      3'd1, 3'd5: return "R2/R4/R5/R9";
      3'd2, 3'd3: return "R3/R4/R5/R6";
      3'd4:       return hit ? "R6" : "R7";
      default:    return "R1";
    endcase
  endfunction

  task automatic check(input string req);
    logic [7:0] e;
    e = exp_word(op_mode, array_data, prog_msb, sector_hit, time_limit, m_t6, m_t2);
    checks++;
    if (read_data !== e) begin
      errors++;
      $display("FAIL %s mode=%0d actual=%02h expected=%02h", req, op_mode, read_data, e);
    end
  endtask

  task automatic step(input logic [2:0] m, input logic [7:0] arr, input logic msb,
      input logic hit, input logic tmo, input logic strb, input logic oe, input string req);
    @(negedge clk);
    op_mode = m; array_data = arr; prog_msb = msb; sector_hit = hit;
    time_limit = tmo; rd_strobe = strb; out_en = oe;
    @(negedge clk);
    #1 check(req);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    array_data = 8'hA5;
    repeat (3) @(negedge clk);
    #1 check("R1");  // reset: pass-through
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 check("R1");

    // R2 program, with reads advancing bit 6 (R4)
    step(3'd1, 8'h11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R2");
    step(3'd1, 8'h11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R4");
    step(3'd1, 8'h11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R4");
    step(3'd1, 8'h11, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R5");
    // R10: strobe held high counts once
    step(3'd1, 8'h11, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R10");
    step(3'd1, 8'h11, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R10");
    // R10: output enable off blocks the edge
    step(3'd1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
    step(3'd1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R10");
    step(3'd0, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    // R8: a new erase starts with cleared toggles
    step(3'd2, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R8");
    step(3'd2, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R3");
    step(3'd2, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R3");
    // R8: into suspend and back keeps the phase; R6 and R7 reads
    step(3'd4, 8'h3C, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R8");
    step(3'd4, 8'h3C, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R6");
    step(3'd4, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
    step(3'd4, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R7");
    step(3'd4, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R7");
    step(3'd5, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R2");
    step(3'd3, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R3");
    step(3'd0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R3");
    // R1: invalid codes behave as idle
    step(3'd6, 8'hC3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R1");
    step(3'd7, 8'h96, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R1");

    // constrained random stimulus against the model
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] m;
      m = op_mode;
      if ($urandom_range(0, 3) == 0) m = 3'($urandom_range(0, 7));
      step(m, 8'($urandom), 1'($urandom), 1'($urandom), ($urandom_range(0, 7) == 0),
           ($urandom_range(0, 2) != 0), ($urandom_range(0, 4) != 0),
           req_of(m, sector_hit));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule